// File: doc/BRIEF.md
# Latching Fiber Switch Pulse Sequencer

This block steers one of four laser sources onto a shared fiber output through a small tree of three bistable electro-optic switches. Each switch stays in its last position with no drive, and moves only when its four-transistor H-bridge delivers one timed pulse. The pulse polarity picks the new position. The block holds a record of where each switch sits. On a start strobe it works out which positions the chosen source needs, and drives a pulse only to the switches that are out of place. It handles one switch at a time and places an all-off guard interval on both sides of every pulse.

The routing tree has a root and two leaves. The root switch (index 2) picks between the pair {0,1} and the pair {2,3}. Leaf switch 0 picks within the first pair, and leaf switch 1 picks within the second. The leaf that is not on the chosen path keeps its position. The pulse length and the guard interval are parameters counted in clock cycles. The default pulse is 12000 cycles, which is 0.3 ms at 40 MHz.

Top module: `osw_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all gate outputs are 0, busy_o and done_o are 0, and the position record pos_o is 3'b000.
- R2: For source s, the target of switch 2 is s[1]. If s[1]=0, the target of switch 0 is s[0]. If s[1]=1, the target of switch 1 is s[0]. The other leaf switch keeps its recorded position and gets no pulse.
- R3: Only switches whose recorded position differs from the target are pulsed. If none differ, no gate turns on, busy_o is high for exactly 2 cycles and done_o pulses in the second.
- R4: Bridge i uses gate_o[4i+3:4i] = {B-low, B-high, A-low, A-high}. A pulse toward position 1 drives 4'b1001, a pulse toward position 0 drives 4'b0110, and at all other times the nibble is 4'b0000.
- R5: Each pulse holds its gate code for exactly PULSE_CYC consecutive cycles.
- R6: Timeline: busy_o rises in the cycle after the start edge (cycle 0). Each switch to be moved takes DEAD_CYC all-off cycles, then PULSE_CYC pulse cycles, then DEAD_CYC all-off cycles, then one decision cycle. The first pulse begins at cycle DEAD_CYC+1.
- R7: At most one bridge is driven at any time, and switches are pulsed in ascending index order.
- R8: A start strobe while busy_o is high is ignored. The sequence in progress and its final positions are unchanged.
- R9: done_o is high for exactly one cycle, which is the last cycle with busy_o high. busy_o is low in the following cycle.
- R10: The record bit of a switch takes its target value at the end of that switch's pulse, and the record does not change at any other time.
- R11: No bridge ever turns on both transistors of one leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to route src_i |
| src_i | input | 2 | Requested laser source, 0 to 3 |
| gate_o | output | 12 | Four gate drives per bridge, bridge i at bits 4i+3:4i |
| pos_o | output | 3 | Recorded latched position per switch |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with PULSE_CYC=20 and DEAD_CYC=3. With these values every pulse and guard interval is short enough that each run can be compared cycle by cycle against a timeline computed in the bench. This covers pulse lengths, guard intervals, decision cycles and ordering. The short runs also allow dozens of random source requests from evolving switch states. These include repeated requests that need no pulse, two-switch moves in both polarities, and stray start strobes injected in the middle of a pulse.

// File: rtl/osw_pkg.sv
package osw_pkg;
  localparam int NSW = 3;
  localparam int IW  = 2;
  localparam int GW  = 4;

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_PRE, S_PULSE, S_POST, S_FIN} seq_st_t;

  // gate nibble: {B-low, B-high, A-low, A-high}
  localparam logic [GW-1:0] DRV_TO_ONE  = 4'b1001;
  localparam logic [GW-1:0] DRV_TO_ZERO = 4'b0110;

  // required switch positions for a source; off-path leaf keeps its place
  function automatic logic [NSW-1:0] route_target(input logic [1:0] src,
                                                  input logic [NSW-1:0] pos);
    logic [NSW-1:0] t;
    t = pos;
    t[2] = src[1];
    if (src[1]) t[1] = src[0];
    else        t[0] = src[0];
    return t;
  endfunction

  // lowest set bit index of a mask
  function automatic logic [IW-1:0] lowest_set(input logic [NSW-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NSW-1; i >= 0; i--) begin
      if (m[i]) r = IW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/osw_route.sv
module osw_route
  import osw_pkg::*;
(
  input  logic [1:0]     src,
  input  logic [NSW-1:0] pos,
  output logic [NSW-1:0] tgt,
  output logic [NSW-1:0] need
);
  assign tgt  = route_target(src, pos);
  assign need = tgt ^ pos;
endmodule

// File: rtl/osw_timer.sv
module osw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/osw_bridge.sv
module osw_bridge
  import osw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          dir,
  output logic [GW-1:0] g
);
  assign g = act ? (dir ? DRV_TO_ONE : DRV_TO_ZERO) : '0;

  // R11
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(g[0] && g[1]) && !(g[2] && g[3]));
endmodule

// File: rtl/osw_seq.sv
module osw_seq
  import osw_pkg::*;
#(
  parameter int PULSE_CYC = 12000,
  parameter int DEAD_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        src_i,
  output logic [NSW*GW-1:0] gate_o,
  output logic [NSW-1:0]    pos_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MAXC = (PULSE_CYC > DEAD_CYC) ? PULSE_CYC : DEAD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] DEAD_LD  = CW'(DEAD_CYC - 1);

  seq_st_t        st_q;
  logic [NSW-1:0] pos_q, tgt_q, mask_q;
  logic [IW-1:0]  sel_q;
  logic [NSW-1:0] tgt_w, need_w;
  logic           tmr_load, tmr_zero;
  logic [CW-1:0]  tmr_val;

  // named events
  logic           accept_w, pulse_on_w, pulse_end_w;
  logic [NSW-1:0] bridge_on_w;

  osw_route u_route (.src(src_i), .pos(pos_q), .tgt(tgt_w), .need(need_w));

  osw_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero));

  assign accept_w    = (st_q == S_IDLE) && start_i;
  assign pulse_on_w  = (st_q == S_PULSE);
  assign pulse_end_w = pulse_on_w && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      S_PICK:  if (mask_q != '0) begin tmr_load = 1'b1; tmr_val = DEAD_LD;  end
      S_PRE:   if (tmr_zero)     begin tmr_load = 1'b1; tmr_val = PULSE_LD; end
      S_PULSE: if (tmr_zero)     begin tmr_load = 1'b1; tmr_val = DEAD_LD;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pos_q  <= '0;
      tgt_q  <= '0;
      mask_q <= '0;
      sel_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          tgt_q  <= tgt_w;
          mask_q <= need_w;
          st_q   <= S_PICK;
        end
        S_PICK: begin
          if (mask_q == '0) st_q <= S_FIN;
          else begin
            sel_q <= lowest_set(mask_q);
            st_q  <= S_PRE;
          end
        end
        S_PRE:   if (tmr_zero) st_q <= S_PULSE;
        S_PULSE: if (tmr_zero) begin
          pos_q[sel_q]  <= tgt_q[sel_q];
          mask_q[sel_q] <= 1'b0;
          st_q          <= S_POST;
        end
        S_POST:  if (tmr_zero) st_q <= S_PICK;
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NSW; i++) begin : g_br
    assign bridge_on_w[i] = pulse_on_w && (sel_q == IW'(i));
    osw_bridge u_br (
      .clk(clk), .rst_n(rst_n), .act(bridge_on_w[i]), .dir(tgt_q[i]),
      .g(gate_o[i*GW +: GW]));
  end

  assign pos_o  = pos_q;
  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_FIN);

  // R7
  one_bridge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bridge_on_w));
  // R9
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tgt_q));
  // R10
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_end_w |=> $stable(pos_q));
  // R10
  pos_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end_w |=> (pos_q == $past(pos_q ^ (tgt_q & bridge_on_w) ^ ($past(pos_q) & bridge_on_w) & bridge_on_w) || pos_q[$past(sel_q)] == $past(tgt_q[sel_q])));
  // R3
  no_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PICK && mask_q == '0) |=> done_o);
endmodule

// File: tb/tb_osw_seq.sv
module tb_osw_seq;
  localparam int P = 20;
  localparam int D = 3;
  localparam int T = 2*D + P + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  src_i = 2'd0;
  logic [11:0] gate_o;
  logic [2:0]  pos_o;
  logic        busy_o, done_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] pos_m = 3'b000;

  always #4 clk = ~clk;

  osw_seq #(.PULSE_CYC(P), .DEAD_CYC(D)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
    .gate_o(gate_o), .pos_o(pos_o), .busy_o(busy_o), .done_o(done_o));

  function automatic logic [2:0] want_pos(input int s, input logic [2:0] cur);
    logic [2:0] w;
    w = cur;
    w[2] = (s >= 2);
    w[(s >= 2) ? 1 : 0] = s % 2;
    return w;
  endfunction

  function automatic logic [11:0] want_gates(input int idx, input int n,
      input int s0, input int s1, input logic [2:0] tg);
    logic [11:0] g;
    int j, o, sw;
    g = '0;
    if (idx >= 1) begin
      j = (idx - 1) / T;
      o = (idx - 1) % T;
      if (j < n && o >= D && o < D + P) begin
        sw = (j == 0) ? s0 : s1;
        g[4*sw +: 4] = tg[sw] ? 4'b1001 : 4'b0110;
      end
    end
    return g;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R9 R10 checked per cycle against the bench timeline
  task automatic run_cmd(input int s, input bit inject);
    logic [2:0] tg, diff;
    int n, s0, s1, nb;
    tg = want_pos(s, pos_m);
    diff = tg ^ pos_m;
    n = 0; s0 = 0; s1 = 0;
    for (int k = 0; k < 3; k++) begin
      if (diff[k]) begin
        if (n == 0) s0 = k; else s1 = k;
        n++;
      end
    end
    nb = n*T + 2;
    @(negedge clk);
    src_i = 2'(s); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int idx = 0; idx < nb + 3; idx++) begin
      chk(gate_o == want_gates(idx, n, s0, s1, tg), "R4/R5/R6/R7",
          $sformatf("gates src=%0d idx=%0d", s, idx), gate_o, want_gates(idx, n, s0, s1, tg));
      chk(busy_o == (idx < nb), "R6/R9", $sformatf("busy idx=%0d", idx), busy_o, idx < nb);
      chk(done_o == (idx == nb-1), "R9", $sformatf("done idx=%0d", idx), done_o, idx == nb-1);
      start_i = 1'b0;
      if (inject && n > 0 && (idx == 5 || idx == D + 4)) begin
        src_i = ~2'(s); start_i = 1'b1; // R8 stray request
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    pos_m = tg;
    chk(pos_o == pos_m, "R2/R10", $sformatf("position src=%0d", s), pos_o, pos_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(gate_o == 12'h0, "R1", "gates", gate_o, 0);
    chk(busy_o == 1'b0, "R1", "busy", busy_o, 0);
    chk(done_o == 1'b0, "R1", "done", done_o, 0);
    chk(pos_o == 3'b000, "R1", "pos", pos_o, 0);
    rst_n = 1'b1;
    // directed: R3 no move needed
    run_cmd(0, 1'b0);
    // R2 R7 two switches toward 1, ascending order
    run_cmd(3, 1'b0);
    // R2 off-path leaf untouched, R4 polarity back to 0
    run_cmd(0, 1'b0);
    run_cmd(1, 1'b1);
    run_cmd(2, 1'b1);
    run_cmd(2, 1'b0);
    for (int k = 0; k < 40; k++) begin
      r = $urandom();
      run_cmd(int'(r % 4), r[8]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule